// File: doc/BRIEF.md
# Asynchronous Character Frame Codec

This block turns a data byte into the serial bit pattern of an asynchronous character and checks a captured pattern on the way back in. Both directions follow one line-configuration word. That word sets the word length, the parity mode and the stop-bit count. On the send side a byte goes in on a valid/ready stream. Out comes a frame vector, first bit at index 0, with the number of bits it holds. On the receive side a captured frame vector goes in on a second valid/ready stream. Out comes the extracted data byte with parity-error and framing-error flags. The start bit is not part of either vector; the serialiser that sits next to this block adds and strips it.

Each stream has a single output register. An input is accepted when its output register is empty, or when that register is being drained in the same cycle. The result appears on the output one clock after acceptance. While the output is valid and not taken, it holds steady and the input's ready stays low. From the same configuration and a 16-bit baud divisor, the block also keeps a registered count of divisor ticks per character. That count follows its inputs with one clock of latency.

Top module: `uart_frame_codec`

## Requirements
- R1: Configuration bits [1:0] give the word length as code+5, so 5 to 8 data bits. Data bits at or above the word length appear as 0, both in the frame vector and in the received data. Vector bits at or above the reported length are 0.
- R2: With parity enabled (cfg[3]=1) and stick parity off (cfg[5]=0), the sent parity bit sits right after the data bits. With cfg[4]=1 it is the XOR of the data bits; with cfg[4]=0 it is that XOR inverted.
- R3: With parity enabled and cfg[5]=1, the sent parity bit is always 1, whatever cfg[4] says. The receiver flags a parity error exactly when that bit is 0.
- R4: The receiver XORs the data bits with the parity bit. The result must be 0 when cfg[4]=1 and 1 when cfg[4]=0; otherwise res_perr is 1. With parity disabled, res_perr is always 0.
- R5: The receiver sets res_ferr when the first stop bit, right after the data or parity bit, is 0.
- R6: When cfg[2]=1 the sender emits a second stop bit of 1. The receiver also sets res_ferr when that second stop bit is 0.
- R7: frm_len equals word length + parity bit + stop bits (2 when cfg[2]=1, else 1). The stop bits are 1.
- R8: char_ticks = floor(D × (1 + word length + parity + S)), with D the divisor. S is 1 when cfg[2]=0, 1.5 for a 5-bit word with cfg[2]=1, and 2 otherwise. It is updated one clock after its inputs change.
- R9: A divisor of 0 is treated as 1 in the R8 count.
- R10: While frm_valid or res_valid is 1 and its ready is 0, that output's data hold steady and the matching input ready is 0. A new item is accepted in the same cycle the old one is taken.
- R11: After reset, frm_valid, res_valid and char_ticks are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_cfg | input | 6 | Line configuration: [1:0] word code, [2] extra stop, [3] parity on, [4] even, [5] stick |
| divisor | input | 16 | Baud divisor in ticks per bit |
| tx_valid | input | 1 | Send byte valid |
| tx_ready | output | 1 | Send byte accepted when high with tx_valid |
| tx_data | input | 8 | Byte to frame |
| frm_valid | output | 1 | Frame vector valid |
| frm_ready | input | 1 | Downstream takes the frame |
| frm_bits | output | 11 | Frame vector, first bit at index 0 |
| frm_len | output | 4 | Number of bits in the frame vector |
| cap_valid | input | 1 | Captured frame valid |
| cap_ready | output | 1 | Captured frame accepted |
| cap_bits | input | 11 | Captured frame vector, first data bit at index 0 |
| res_valid | output | 1 | Check result valid |
| res_ready | input | 1 | Downstream takes the result |
| res_data | output | 8 | Extracted data, high bits zero |
| res_perr | output | 1 | Parity error |
| res_ferr | output | 1 | Framing error |
| char_ticks | output | 21 | Divisor ticks per character |

## Verification
The bench targets three risky areas. The first is where the parity and stop bits land for each word length. A design that places them at a fixed offset would produce frames that are wrong for any word shorter than eight bits. The second is the receive-side parity check. If stick parity were treated as even parity, or the parity bit were left out of the XOR, ordinary frames would be flagged while corrupt ones passed. A second stop bit of 0 must raise a framing error only when two stops are selected. The tick count is probed at the 1.5-stop case, at a zero divisor and at the largest divisor. The half-bit term and the product width show up exactly there. Stalled outputs are checked to hold their value and to refuse new input until drained.

// File: rtl/uart_frame_pkg.sv
package uart_frame_pkg;
  localparam int unsigned CFG_W = 6;

  typedef struct packed {
    logic       stick;
    logic       even;
    logic       par_en;
    logic       two_stop;
    logic [1:0] wcode;
  } line_cfg_t;
endpackage

// File: rtl/frame_builder.sv
module frame_builder
  import uart_frame_pkg::*;
#(
  parameter int unsigned MAX_DATA = 8,
  localparam int unsigned FRAME_W = MAX_DATA + 3,
  localparam int unsigned LEN_W   = $clog2(FRAME_W + 1)
) (
  input  line_cfg_t            cfg,
  input  logic [MAX_DATA-1:0]  data,
  output logic [FRAME_W-1:0]   bits,
  output logic [LEN_W-1:0]     len
);
  logic [LEN_W-1:0] nb;
  logic [LEN_W-1:0] pos;
  logic             xsum;

  always_comb begin
    nb   = LEN_W'(cfg.wcode) + LEN_W'(5);
    bits = '0;
    xsum = 1'b0;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (LEN_W'(i) < nb) begin
        bits[i] = data[i];
        xsum    = xsum ^ data[i];
      end
    end
    pos = nb;
    if (cfg.par_en) begin
      bits[pos] = cfg.stick ? 1'b1 : (cfg.even ? xsum : ~xsum);
      pos       = pos + LEN_W'(1);
    end
    bits[pos] = 1'b1;
    pos       = pos + LEN_W'(1);
    if (cfg.two_stop) begin
      bits[pos] = 1'b1;
      pos       = pos + LEN_W'(1);
    end
    len = pos;
  end
endmodule

// File: rtl/frame_checker.sv
module frame_checker
  import uart_frame_pkg::*;
#(
  parameter int unsigned MAX_DATA = 8,
  localparam int unsigned FRAME_W = MAX_DATA + 3,
  localparam int unsigned LEN_W   = $clog2(FRAME_W + 1)
) (
  input  line_cfg_t            cfg,
  input  logic [FRAME_W-1:0]   bits,
  output logic [MAX_DATA-1:0]  data,
  output logic                 perr,
  output logic                 ferr
);
  logic [LEN_W-1:0] nb;
  logic [LEN_W-1:0] pos;
  logic             xsum;
  logic             pbit;

  always_comb begin
    nb   = LEN_W'(cfg.wcode) + LEN_W'(5);
    data = '0;
    xsum = 1'b0;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (LEN_W'(i) < nb) begin
        data[i] = bits[i];
        xsum    = xsum ^ bits[i];
      end
    end
    pos  = nb;
    perr = 1'b0;
    pbit = 1'b0;
    if (cfg.par_en) begin
      pbit = bits[pos];
      if (cfg.stick)     perr = ~pbit;
      else if (cfg.even) perr = xsum ^ pbit;
      else               perr = ~(xsum ^ pbit);
      pos = pos + LEN_W'(1);
    end
    ferr = ~bits[pos];
    pos  = pos + LEN_W'(1);
    if (cfg.two_stop) ferr = ferr | ~bits[pos];
  end
endmodule

// File: rtl/char_timer.sv
module char_timer
  import uart_frame_pkg::*;
#(
  parameter int unsigned DIV_W = 16,
  localparam int unsigned HALF_W = 5,
  localparam int unsigned TICK_W = DIV_W + HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  line_cfg_t         cfg,
  input  logic [DIV_W-1:0]  divisor,
  output logic [TICK_W-1:0] ticks
);
  logic [HALF_W-1:0] half_bits;
  logic [HALF_W-1:0] stop_half;
  logic [DIV_W-1:0]  div_eff;
  logic [TICK_W-1:0] prod;

  always_comb begin
    if (!cfg.two_stop)          stop_half = HALF_W'(2);
    else if (cfg.wcode == 2'd0) stop_half = HALF_W'(3);
    else                        stop_half = HALF_W'(4);
    half_bits = HALF_W'(2) * (HALF_W'(6) + HALF_W'(cfg.wcode) + HALF_W'(cfg.par_en))
              + stop_half;
    div_eff   = (divisor == '0) ? DIV_W'(1) : divisor;
    prod      = TICK_W'(div_eff) * TICK_W'(half_bits);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ticks <= '0;
    else        ticks <= prod >> 1;
  end
endmodule

// File: rtl/uart_frame_codec.sv
module uart_frame_codec
  import uart_frame_pkg::*;
#(
  parameter int unsigned MAX_DATA = 8,
  parameter int unsigned DIV_W    = 16,
  localparam int unsigned FRAME_W = MAX_DATA + 3,
  localparam int unsigned LEN_W   = $clog2(FRAME_W + 1),
  localparam int unsigned TICK_W  = DIV_W + 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CFG_W-1:0]    line_cfg,
  input  logic [DIV_W-1:0]    divisor,
  input  logic                tx_valid,
  output logic                tx_ready,
  input  logic [MAX_DATA-1:0] tx_data,
  output logic                frm_valid,
  input  logic                frm_ready,
  output logic [FRAME_W-1:0]  frm_bits,
  output logic [LEN_W-1:0]    frm_len,
  input  logic                cap_valid,
  output logic                cap_ready,
  input  logic [FRAME_W-1:0]  cap_bits,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [MAX_DATA-1:0] res_data,
  output logic                res_perr,
  output logic                res_ferr,
  output logic [TICK_W-1:0]   char_ticks
);
  line_cfg_t           cfg;
  logic [FRAME_W-1:0]  nxt_bits;
  logic [LEN_W-1:0]    nxt_len;
  logic [MAX_DATA-1:0] nxt_data;
  logic                nxt_perr;
  logic                nxt_ferr;

  assign cfg       = line_cfg_t'(line_cfg);
  assign tx_ready  = ~frm_valid | frm_ready;
  assign cap_ready = ~res_valid | res_ready;

  frame_builder #(.MAX_DATA(MAX_DATA)) i_build (
    .cfg(cfg), .data(tx_data), .bits(nxt_bits), .len(nxt_len)
  );

  frame_checker #(.MAX_DATA(MAX_DATA)) i_check (
    .cfg(cfg), .bits(cap_bits), .data(nxt_data), .perr(nxt_perr), .ferr(nxt_ferr)
  );

  char_timer #(.DIV_W(DIV_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .divisor(divisor), .ticks(char_ticks)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frm_valid <= 1'b0;
      frm_bits  <= '0;
      frm_len   <= '0;
    end else if (tx_ready) begin
      frm_valid <= tx_valid;
      if (tx_valid) begin
        frm_bits <= nxt_bits;
        frm_len  <= nxt_len;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_perr  <= 1'b0;
      res_ferr  <= 1'b0;
    end else if (cap_ready) begin
      res_valid <= cap_valid;
      if (cap_valid) begin
        res_data <= nxt_data;
        res_perr <= nxt_perr;
        res_ferr <= nxt_ferr;
      end
    end
  end
endmodule

// File: rtl/uart_frame_codec_sva.sv
module uart_frame_codec_sva #(
  parameter int unsigned FRAME_W = 11,
  parameter int unsigned LEN_W   = 4,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned TICK_W  = 21
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frm_valid,
  input logic               frm_ready,
  input logic [FRAME_W-1:0] frm_bits,
  input logic [LEN_W-1:0]   frm_len,
  input logic               tx_ready,
  input logic               res_valid,
  input logic               res_ready,
  input logic [DATA_W-1:0]  res_data,
  input logic               res_perr,
  input logic               res_ferr,
  input logic               cap_ready,
  input logic [TICK_W-1:0]  char_ticks
);
  logic ticks_live;
  always_ff @(posedge clk) begin
    if (!rst_n) ticks_live <= 1'b0;
    else        ticks_live <= 1'b1;
  end

  a_r10_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && !frm_ready |=> frm_valid && $stable(frm_bits) && $stable(frm_len));

  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_perr)
                                && $stable(res_ferr));

  a_r10_tx_stall: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && !frm_ready |-> !tx_ready);

  a_r10_cap_stall: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !cap_ready);

  a_r1_high_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> (frm_bits >> frm_len) == '0);

  a_r7_last_is_stop: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> frm_len >= LEN_W'(6) && frm_bits[frm_len - LEN_W'(1)]);

  a_r9_ticks_floor: assert property (@(posedge clk) disable iff (!rst_n)
    ticks_live |-> char_ticks >= TICK_W'(7));
endmodule

bind uart_frame_codec uart_frame_codec_sva #(
  .FRAME_W(FRAME_W), .LEN_W(LEN_W), .DATA_W(MAX_DATA), .TICK_W(TICK_W)
) i_sva (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
  .frm_bits(frm_bits), .frm_len(frm_len), .tx_ready(tx_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
  .res_perr(res_perr), .res_ferr(res_ferr), .cap_ready(cap_ready),
  .char_ticks(char_ticks)
);

// File: tb/test_uart_frame_codec.sv
module test_uart_frame_codec;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  line_cfg = '0;
  logic [15:0] divisor = 16'd1;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [7:0]  tx_data = '0;
  logic        frm_valid;
  logic        frm_ready = 1'b1;
  logic [10:0] frm_bits;
  logic [3:0]  frm_len;
  logic        cap_valid = 1'b0;
  logic        cap_ready;
  logic [10:0] cap_bits = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [7:0]  res_data;
  logic        res_perr;
  logic        res_ferr;
  logic [20:0] char_ticks;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_frame_codec i_uart_frame_codec (
    .clk(clk), .rst_n(rst_n), .line_cfg(line_cfg), .divisor(divisor),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_bits(frm_bits), .frm_len(frm_len),
    .cap_valid(cap_valid), .cap_ready(cap_ready), .cap_bits(cap_bits),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_perr(res_perr), .res_ferr(res_ferr), .char_ticks(char_ticks)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected frame from R1, R2, R3, R6, R7.
  function automatic void exp_frame(input logic [5:0] c, input logic [7:0] d,
                                    output logic [10:0] b, output int n);
    int w = int'(c[1:0]) + 5;
    logic p = 1'b0;
    b = '0;
    for (int k = 0; k < w; k++) begin b[k] = d[k]; p ^= d[k]; end
    n = w;
    if (c[3]) begin b[n] = c[5] ? 1'b1 : (c[4] ? p : ~p); n++; end
    b[n] = 1'b1; n++;
    if (c[2]) begin b[n] = 1'b1; n++; end
  endfunction

  // Expected check result from R1, R3, R4, R5, R6.
  function automatic void exp_check(input logic [5:0] c, input logic [10:0] b,
                                    output logic [7:0] d, output logic pe, output logic fe);
    int w = int'(c[1:0]) + 5;
    int n;
    logic x = 1'b0;
    d = '0;
    for (int k = 0; k < w; k++) begin d[k] = b[k]; x ^= b[k]; end
    n = w; pe = 1'b0;
    if (c[3]) begin
      x ^= b[n];
      pe = c[5] ? ~b[n] : (c[4] ? x : ~x);
      n++;
    end
    fe = ~b[n]; n++;
    if (c[2]) fe |= ~b[n];
  endfunction

  // Expected tick count from R8, R9.
  function automatic longint exp_ticks(input logic [5:0] c, input logic [15:0] dv);
    longint dd = (dv == 0) ? 1 : longint'(dv);
    longint halves = 2 * (1 + longint'(c[1:0]) + 5 + longint'(c[3]));
    if (!c[2]) halves += 2;
    else if (c[1:0] == 2'd0) halves += 3;
    else halves += 4;
    return (dd * halves) / 2;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 frm_valid", frm_valid, 0);
    check("R11 res_valid", res_valid, 0);
    check("R11 char_ticks", char_ticks, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_tx(input string req, input logic [5:0] c, input logic [7:0] d);
    logic [10:0] eb; int en;
    exp_frame(c, d, eb, en);
    @(negedge clk);
    line_cfg = c; tx_data = d; tx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    check({req, " frm_valid"}, frm_valid, 1);
    check({req, " frm_bits"}, frm_bits, eb);
    check({req, " frm_len"}, frm_len, en);
  endtask

  task automatic t_rx(input string req, input logic [5:0] c, input logic [10:0] b);
    logic [7:0] ed; logic ep, ef;
    exp_check(c, b, ed, ep, ef);
    @(negedge clk);
    line_cfg = c; cap_bits = b; cap_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cap_valid = 1'b0;
    check({req, " res_valid"}, res_valid, 1);
    check({req, " res_data"}, res_data, ed);
    check({req, " res_perr"}, res_perr, ep);
    check({req, " res_ferr"}, res_ferr, ef);
  endtask

  task automatic t_ticks(input string req, input logic [5:0] c, input logic [15:0] dv);
    @(negedge clk);
    line_cfg = c; divisor = dv;
    @(posedge clk);
    @(negedge clk);
    check(req, char_ticks, exp_ticks(c, dv));
  endtask

  task automatic t_backpressure();
    logic [10:0] ea, eb; int la, lb;
    exp_frame(6'b011011, 8'h3C, ea, la);
    exp_frame(6'b011011, 8'hC1, eb, lb);
    @(negedge clk);
    frm_ready = 1'b0; line_cfg = 6'b011011; tx_data = 8'h3C; tx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_data = 8'hC1;
    check("R10 tx_ready low while stalled", tx_ready, 0);
    @(posedge clk);
    @(negedge clk);
    check("R10 frame held", frm_bits, ea);
    check("R10 valid held", frm_valid, 1);
    frm_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    check("R10 next frame loaded on drain", frm_bits, eb);
    @(posedge clk);
    @(negedge clk);
    check("R10 valid drops after drain", frm_valid, 0);
    // result stream stall
    res_ready = 1'b0;
    line_cfg = 6'b000011; cap_bits = 11'h1AA; cap_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cap_bits = 11'h055;
    check("R10 cap_ready low while stalled", cap_ready, 0);
    @(posedge clk);
    @(negedge clk);
    check("R10 result held", res_data, 8'hAA);
    res_ready = 1'b1; cap_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R10 result valid drops", res_valid, 0);
  endtask

  initial begin
    t_reset();
    // R1: word lengths mask high data bits
    t_tx("R1 5-bit", 6'b000000, 8'hFF);
    t_tx("R1 6-bit", 6'b000001, 8'hEA);
    // R2: even and odd parity, various words
    t_tx("R2 even 8-bit", 6'b011011, 8'hA5);
    t_tx("R2 odd 8-bit", 6'b001011, 8'hA5);
    t_tx("R2 odd 7-bit", 6'b001010, 8'h81);
    // R3: stick parity overrides even/odd
    t_tx("R3 stick tx", 6'b111001, 8'h00);
    // R6 / R7: two stop bits
    t_tx("R6 two stop", 6'b001111, 8'h5A);
    t_tx("R7 5-bit two stop", 6'b000100, 8'h13);
    // R4: receive parity
    t_rx("R4 even ok", 6'b011011, 11'h2A5);
    t_rx("R4 even bad", 6'b011011, 11'h3A5);
    t_rx("R4 odd ok", 6'b001011, 11'h3A5);
    t_rx("R4 parity off", 6'b000011, 11'h1A5);
    // R3: stick on receive
    t_rx("R3 stick bit zero", 6'b101010, 11'h07F);
    t_rx("R3 stick bit one", 6'b101010, 11'h0FF);
    // R5: first stop zero
    t_rx("R5 stop1 zero", 6'b000011, 11'h0A5);
    t_rx("R5 5-bit stop1 zero", 6'b000000, 11'h01F);
    // R6: second stop
    t_rx("R6 stop2 zero", 6'b000111, 11'h1A5);
    t_rx("R6 stop2 one", 6'b000111, 11'h3A5);
    t_rx("R1 rx mask 6-bit", 6'b000001, 11'h0FF);
    // R8 / R9: character duration
    t_ticks("R8 8N1 div16", 6'b000011, 16'd16);
    t_ticks("R8 5-bit 1.5 stop", 6'b000100, 16'd3);
    t_ticks("R8 7E2 div5", 6'b011110, 16'd5);
    t_ticks("R9 zero divisor", 6'b011111, 16'd0);
    t_ticks("R8 max divisor", 6'b011111, 16'hFFFF);
    t_backpressure();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule